// File: doc/BRIEF.md
# Cascadable Synchronous Decade Counter

This block is a four-bit counter that steps through the decimal digits 0 to 9 on the rising clock edge. It can be cleared to zero or preset to any four-bit value. Both controls are active low and take effect only at a clock edge. The count advances only when two count enables are both high. One of these, the carry-in enable, also gates a combinational carry output. That carry is high only while the digit is 9, so it can drive the carry-in enable of the next digit directly. A chain of these counters therefore forms a multi-digit synchronous decimal counter without extra gating.

Six of the sixteen codes are not decimal digits. If the register holds one of them after a preset, counting brings it back into the decimal sequence within two enabled edges. An asynchronous active-low reset puts the digit at zero. The block releases that reset synchronously through a short synchronizer.

Top module: `dec_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0. After `rst_n` rises, `q` stays 0 until the first edge that follows the internal synchronized release.
- R2: At a rising edge with `clr_n` low, `q` becomes 0. This holds whatever the values of `ld_n`, `cnt_en` and `carry_in` are, so clear has priority over preset.
- R3: At a rising edge with `clr_n` high and `ld_n` low, `q` takes the value of `din` (any of the 16 codes). The enables have no effect on that edge.
- R4: At a rising edge with both controls high and both `cnt_en` and `carry_in` high, a digit from 0 to 8 increments by one, and 9 becomes 0.
- R5: At a rising edge with both controls high and at least one enable low, `q` keeps its value.
- R6: `carry_out` is high exactly when `carry_in` is high and `q` equals 9 (binary 1001). It follows its inputs with no clock edge in between.
- R7: When counting, the non-decimal codes step 10→11→6, 12→13→4 and 14→15→2. Each therefore reaches a digit from 0 to 9 within two counting edges.
- R8: Two stages, with the upper stage's `carry_in` taken from the lower stage's `carry_out` and both `cnt_en` high, count 00 to 99 and then wrap to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Synchronous clear to zero, active low |
| ld_n | input | 1 | Synchronous preset from `din`, active low |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| carry_in | input | 1 | Count enable that also gates `carry_out` |
| din | input | 4 | Preset value, bit 0 least significant |
| q | output | 4 | Current digit, bit 0 least significant |
| carry_out | output | 1 | High while `carry_in` is high and `q` is 9 |

## Verification
Clear and preset can both be active at the same edge. Preset can also arrive while both enables are high, so a count would be due on that same edge. Directed vectors assert clear and preset together with differing `din`, and assert preset at a count of 9 with both enables high. The randomized phase produces these overlaps many times over. At each edge, a bench model that applies clear, then preset, then count in that priority order decides the expected digit. A mismatch shows which action won.

// File: rtl/dec_ctr_pkg.sv
package dec_ctr_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_TOP  = digit_t'(9);
  localparam digit_t DIGIT_ZERO = digit_t'(0);

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctl_op_e;
endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("dec_rst_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], 1'b1};
    end
  end

  assign rst_q_n = chain_q[LAST];
endmodule

// File: rtl/dec_next_state.sv
module dec_next_state
  import dec_ctr_pkg::*;
(
  input  digit_t cur,
  input  logic   clr_n,
  input  logic   ld_n,
  input  logic   cnt_en,
  input  logic   carry_in,
  input  digit_t din,
  output digit_t nxt,
  output logic   upd_en
);
  ctl_op_e op;
  digit_t  succ;

  // control priority: clear, then preset, then count
  always_comb begin
    if (!clr_n) begin
      op = OP_CLEAR;
    end else if (!ld_n) begin
      op = OP_LOAD;
    end else if (cnt_en && carry_in) begin
      op = OP_COUNT;
    end else begin
      op = OP_HOLD;
    end
  end

  // successor including the recovery path for codes 10..15
  always_comb begin
    unique case (cur)
      DIGIT_TOP:   succ = DIGIT_ZERO;
      digit_t'(10): succ = digit_t'(11);
      digit_t'(11): succ = digit_t'(6);
      digit_t'(12): succ = digit_t'(13);
      digit_t'(13): succ = digit_t'(4);
      digit_t'(14): succ = digit_t'(15);
      digit_t'(15): succ = digit_t'(2);
      default:     succ = cur + digit_t'(1);
    endcase
  end

  always_comb begin
    upd_en = 1'b1;
    nxt    = cur;
    unique case (op)
      OP_CLEAR: nxt = DIGIT_ZERO;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = succ;
      default: begin
        upd_en = 1'b0;
        nxt    = cur;
      end
    endcase
  end
endmodule

// File: rtl/dec_carry.sv
module dec_carry
  import dec_ctr_pkg::*;
(
  input  digit_t cur,
  input  logic   carry_in,
  output logic   carry_out
);
  logic at_top;

  assign at_top    = (cur == DIGIT_TOP);
  assign carry_out = carry_in & at_top;
endmodule

// File: rtl/dec_counter.sv
module dec_counter
  import dec_ctr_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_n,
  input  logic                ld_n,
  input  logic                cnt_en,
  input  logic                carry_in,
  input  logic [DIGIT_W-1:0]  din,
  output logic [DIGIT_W-1:0]  q,
  output logic                carry_out
);
  logic   rst_q_n;
  digit_t cnt_q;
  digit_t cnt_d;
  logic   cnt_upd;

  dec_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dec_next_state u_next (
    .cur      (cnt_q),
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .din      (din),
    .nxt      (cnt_d),
    .upd_en   (cnt_upd)
  );

  // all four bits share one clock and one enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q <= DIGIT_ZERO;
    end else if (cnt_upd) begin
      cnt_q <= cnt_d;
    end
  end

  dec_carry u_carry (
    .cur       (cnt_q),
    .carry_in  (carry_in),
    .carry_out (carry_out)
  );

  assign q = cnt_q;
endmodule

// File: rtl/dec_counter_chk.sv
module dec_counter_chk
  import dec_ctr_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         rst_q_n,
  input logic         clr_n,
  input logic         ld_n,
  input logic         cnt_en,
  input logic         carry_in,
  input logic [3:0]   din,
  input logic [3:0]   q,
  input logic         carry_out
);
  logic counting;
  assign counting = clr_n && ld_n && cnt_en && carry_in;

  always_comb begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (q == 4'd0 || $isunknown(q));
    end
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr_n |=> q == 4'd0);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && !ld_n) |=> q == $past(din));

  p_count_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (counting && q < 4'd9) |=> q == $past(q) + 4'd1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (counting && q == 4'd9) |=> q == 4'd0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && ld_n && !(cnt_en && carry_in)) |=> $stable(q));

  p_carry_nine_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    carry_out |-> (q == 4'd9 && carry_in));

  p_carry_gate_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !carry_in |-> !carry_out);

  p_recover_even_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (counting && q > 4'd9 && !q[0]) |=> (q > 4'd9 && q[0]));

  p_recover_odd_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (counting && q > 4'd9 && q[0]) |=> q <= 4'd9);
endmodule

bind dec_counter dec_counter_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q_n   (rst_q_n),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .cnt_en    (cnt_en),
  .carry_in  (carry_in),
  .din       (din),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/dec_counter_tb_top.sv
module dec_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic clr_lo, ld_lo, p_lo, t_lo;
  logic clr_hi, ld_hi, p_hi;
  logic [3:0] d_lo, d_hi;
  logic [3:0] q_lo, q_hi;
  logic rco_lo, rco_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [3:0] e_lo, e_hi;

  always #2.5 clk = ~clk;

  dec_counter dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_lo), .ld_n(ld_lo),
    .cnt_en(p_lo), .carry_in(t_lo), .din(d_lo),
    .q(q_lo), .carry_out(rco_lo)
  );

  dec_counter dut_hi_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_hi), .ld_n(ld_hi),
    .cnt_en(p_hi), .carry_in(rco_lo), .din(d_hi),
    .q(q_hi), .carry_out(rco_hi)
  );

  function automatic logic [3:0] succ(input logic [3:0] v);
    case (v)
      4'd9:  return 4'd0;
      4'd10: return 4'd11;
      4'd11: return 4'd6;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd2;
      default: return v + 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] m_next(input logic [3:0] v, input logic c,
      input logic l, input logic p, input logic t, input logic [3:0] dv);
    if (!c) return 4'd0;
    if (!l) return dv;
    if (p && t) return succ(v);
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic c0, input logic l0, input logic [3:0] dv0,
      input logic p0, input logic t0, input logic c1, input logic l1,
      input logic [3:0] dv1, input logic p1, input string tag);
    logic r_lo, r_hi;
    clr_lo = c0; ld_lo = l0; d_lo = dv0; p_lo = p0; t_lo = t0;
    clr_hi = c1; ld_hi = l1; d_hi = dv1; p_hi = p1;
    #1;
    r_lo = t0 && (e_lo == 4'd9);
    r_hi = r_lo && (e_hi == 4'd9);
    chk({tag, " R6 carry lo"}, int'(rco_lo), int'(r_lo));
    chk({tag, " R6 carry hi"}, int'(rco_hi), int'(r_hi));
    @(posedge clk);
    e_lo = m_next(e_lo, c0, l0, p0, t0, dv0);
    e_hi = m_next(e_hi, c1, l1, p1, r_lo, dv1);
    @(negedge clk);
    chk({tag, " q lo"}, int'(q_lo), int'(e_lo));
    chk({tag, " q hi"}, int'(q_hi), int'(e_hi));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    clr_lo = 1'b0; ld_lo = 1'b1; p_lo = 1'b1; t_lo = 1'b1; d_lo = 4'd0;
    clr_hi = 1'b0; ld_hi = 1'b1; p_hi = 1'b1; d_hi = 4'd0;
    e_lo = 4'd0; e_hi = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset lo", int'(q_lo), 0);
    chk("R1 reset hi", int'(q_hi), 0);
    rst_n = 1'b1;
    // enables high with controls inactive during synchronized release
    clr_lo = 1'b1; clr_hi = 1'b1;
    @(negedge clk);
    chk("R1 release lo", int'(q_lo), 0);
    @(negedge clk);
    // clear held for safety until sync completes
    apply(0,1,4'd0,1,1, 0,1,4'd0,1, "R1 settle");

    // R8: cascade 00..99 and wrap
    for (int i = 0; i < 100; i++)
      apply(1,1,4'd0,1,1, 1,1,4'd0,1, "R8 R4 cascade");
    chk("R8 wrap to 00", int'({q_hi, q_lo}), 0);

    // R2: clear and load same edge, clear wins
    apply(1,0,4'd7,0,0, 1,0,4'd3,0, "R3 preset");
    apply(0,0,4'd5,1,1, 0,0,4'd8,1, "R2 clear beats load");
    chk("R2 clear beats load", int'(q_lo), 0);

    // R3: load at 9 with enables high, no count that edge
    apply(1,0,4'd9,0,0, 1,1,4'd0,0, "R3 preset 9");
    apply(1,0,4'd4,1,1, 1,1,4'd0,0, "R3 load over count");
    chk("R3 load over count", int'(q_lo), 4);

    // R5: hold with either enable low
    apply(1,1,4'd0,0,1, 1,1,4'd0,0, "R5 hold enp low");
    apply(1,1,4'd0,1,0, 1,1,4'd0,0, "R5 hold ent low");
    chk("R5 hold", int'(q_lo), 4);

    // R6: at 9 with carry_in low, no carry
    apply(1,0,4'd9,0,0, 1,1,4'd0,0, "R6 preset 9");
    apply(1,1,4'd0,1,0, 1,1,4'd0,0, "R6 gated carry");
    apply(1,1,4'd0,0,1, 1,1,4'd0,0, "R6 carry with ent");

    // R7: each illegal code recovers within two counts
    for (int c = 10; c < 16; c++) begin
      apply(1,0,4'(c),0,0, 1,1,4'd0,0, "R7 load illegal");
      apply(1,1,4'd0,1,1, 1,1,4'd0,0, "R7 recover step 1");
      apply(1,1,4'd0,1,1, 1,1,4'd0,0, "R7 recover step 2");
      chk("R7 within two counts", int'(q_lo <= 4'd9), 1);
    end

    // mixed random stimulus
    for (int k = 0; k < 600; k++) begin
      logic c0, l0, p0, t0, c1, l1, p1;
      logic [3:0] dv0, dv1;
      c0 = ($urandom % 16) != 0;
      l0 = ($urandom % 8) != 0;
      p0 = ($urandom % 4) != 0;
      t0 = ($urandom % 4) != 0;
      c1 = ($urandom % 32) != 0;
      l1 = ($urandom % 16) != 0;
      p1 = ($urandom % 4) != 0;
      dv0 = 4'($urandom);
      dv1 = 4'($urandom % 10);
      apply(c0,l0,dv0,p0,t0, c1,l1,dv1,p1, "R2 R3 R4 R5 R7 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule